// File: doc/BRIEF.md
# Serially Programmed Dual-Modulus Frequency Divider

This block is the digital heart of a frequency-synthesis loop. A control word of sixteen bits reaches it over a three-wire serial port made of a data line, a shift clock and an enable. The word holds the divide ratio N and three band-select bits. The ratio is sent in complemented form, least significant bit first, and the band bits follow it. Bits are taken on falling edges of the shift clock while enable is high. The word moves into a holding latch when enable drops.

The block divides its fast input clock by N. A modelled 16/17 dual-modulus stage does the first division. A 4-bit swallow counter keeps that stage at 17 for A of its periods. A 9-bit main counter counts M prescaler periods in all, so one output period is 16·M + A input cycles. The output period goes to a phase detector. A one-cycle carry pulse marks each period boundary for test use. The band bits drive the tuner band switches.

The serial pins are sampled in the input-clock domain. A new ratio is loaded into the counters only at the next period boundary, so no period is ever cut short.

Top module: `serial_ratio_divider`

## Requirements
- R1: After reset the band outputs are 000, the carry is low, and the output period is 256 input cycles, because the reset ratio of 0 is raised to the minimum.
- R2: A bit on the data line is shifted in at each falling edge of the shift clock while enable is high. The first 13 bits are the ones' complement of N, least significant bit first. Once latched, the carry-to-carry period equals N input clock cycles.
- R3: The period is exactly 16·M + A, where A is the low 4 bits of N and M is the upper 9 bits. This holds at both ends of the swallow range, A = 0 and A = 15.
- R4: The largest ratio, N = 8191, gives a period of 8191 cycles.
- R5: A latched N below 256 is treated as 256.
- R6: Bits 14 to 16 of the word, in the order sent, appear on band outputs bit 0 to bit 2.
- R7: The latch updates only when enable falls. Shift-clock edges while enable is low have no effect on the band outputs or on the period.
- R8: If more than 16 bits are shifted in one enable window, only the last 16 sent are latched.
- R9: A ratio latched in the middle of a period leaves the length of that period unchanged. The new ratio holds from the next boundary onward.
- R10: The carry is high for exactly one input cycle per output period. The divided output rises in the same cycle as the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided; also samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock; bits taken on its falling edge |
| ser_en | input | 1 | Serial enable; high to shift, falling edge latches |
| div_out | output | 1 | Divided signal for the phase detector |
| carry_out | output | 1 | One-cycle pulse at every divider period boundary |
| band_out | output | 3 | Band-select bits from the latched word |

## Verification
The ratio is exercised with several values, and each one isolates a different part of the counter chain. N = 256 and N = 271 sit at the two ends of the swallow count. N = 300 has a mid-range swallow count, and N = 8191 fills every counter. A ratio below the minimum exercises the clamp. A telegram longer than sixteen bits and a burst of shift edges with enable low separate correct framing from stray shifting. A load made during a long period shows whether the reload waits for the boundary or truncates the period already running.

// File: rtl/divider_pkg.sv
package divider_pkg;
    localparam int DEF_N_W    = 13;
    localparam int DEF_A_W    = 4;
    localparam int DEF_BAND_W = 3;
    localparam int DEF_N_MIN  = 256;
endpackage

// File: rtl/ser_telegram_port.sv
module ser_telegram_port #(
    parameter int N_W    = divider_pkg::DEF_N_W,
    parameter int BAND_W = divider_pkg::DEF_BAND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdat,
    input  logic              sclk,
    input  logic              sen,
    output logic [N_W-1:0]    ratio_o,
    output logic [BAND_W-1:0] band_o
);
    localparam int TEL_W = N_W + BAND_W;

    typedef struct packed {
        logic              sclk;
        logic              en;
        logic [TEL_W-1:0]  sr;
        logic [N_W-1:0]    ratio;
        logic [BAND_W-1:0] band;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     shift_ev;
    logic     latch_ev;

    always_comb begin
        st_d      = st_q;
        st_d.sclk = sclk;
        st_d.en   = sen;
        shift_ev  = st_q.sclk && !sclk && sen;
        latch_ev  = st_q.en && !sen;
        if (shift_ev) begin
            st_d.sr = {sdat, st_q.sr[TEL_W-1:1]};
        end
        if (latch_ev) begin
            st_d.ratio = ~st_q.sr[N_W-1:0];
            st_d.band  = st_q.sr[TEL_W-1:N_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_o = st_q.ratio;
    assign band_o  = st_q.band;

    // R7
    latch_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.en && !sen) |=> ($stable(ratio_o) && $stable(band_o)));
endmodule

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
    parameter int A_W = divider_pkg::DEF_A_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic swallow_i,
    output logic tc_o
);
    localparam int BASE = 2 ** A_W;

    typedef struct packed {
        logic [A_W:0] cnt;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [A_W:0]     limit;

    always_comb begin
        st_d  = st_q;
        limit = swallow_i ? (A_W+1)'(BASE) : (A_W+1)'(BASE - 1);
        tc_o  = (st_q.cnt == limit);
        if (tc_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= (A_W+1)'(BASE));
endmodule

// File: rtl/swallow_main_ctl.sv
module swallow_main_ctl #(
    parameter int N_W   = divider_pkg::DEF_N_W,
    parameter int A_W   = divider_pkg::DEF_A_W,
    parameter int N_MIN = divider_pkg::DEF_N_MIN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tc_i,
    input  logic [N_W-1:0] ratio_i,
    output logic           swallow_o,
    output logic           carry_o,
    output logic           div_o
);
    localparam int M_W = N_W - A_W;
    localparam logic [N_W-1:0] RST_RATIO = N_W'(N_MIN);
    localparam logic [A_W-1:0] RST_A = RST_RATIO[A_W-1:0];
    localparam logic [M_W-1:0] RST_M = RST_RATIO[N_W-1:A_W];

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [M_W-1:0] m;
        logic [M_W-1:0] cur_m;
        logic           carry;
    } ctl_st_t;

    ctl_st_t        st_d, st_q;
    logic [N_W-1:0] eff;
    logic [A_W-1:0] ld_a;
    logic [M_W-1:0] ld_m;

    always_comb begin
        eff  = (ratio_i < RST_RATIO) ? RST_RATIO : ratio_i;
        ld_a = eff[A_W-1:0];
        ld_m = eff[N_W-1:A_W];

        st_d       = st_q;
        st_d.carry = 1'b0;
        if (tc_i) begin
            if (st_q.a != '0) begin
                st_d.a = st_q.a - 1'b1;
            end
            if (st_q.m == M_W'(1)) begin
                st_d.a     = ld_a;
                st_d.m     = ld_m;
                st_d.cur_m = ld_m;
                st_d.carry = 1'b1;
            end else begin
                st_d.m = st_q.m - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.a     <= RST_A;
            st_q.m     <= RST_M;
            st_q.cur_m <= RST_M;
            st_q.carry <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign swallow_o = (st_q.a != '0);
    assign carry_o   = st_q.carry;
    assign div_o     = (st_q.m > (st_q.cur_m >> 1));

    // R3
    swallow_below_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        M_W'(st_q.a) < st_q.m);

    // R10
    carry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> !carry_o);
endmodule

// File: rtl/serial_ratio_divider.sv
module serial_ratio_divider #(
    parameter int N_W    = divider_pkg::DEF_N_W,
    parameter int A_W    = divider_pkg::DEF_A_W,
    parameter int BAND_W = divider_pkg::DEF_BAND_W,
    parameter int N_MIN  = divider_pkg::DEF_N_MIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_en,
    output logic              div_out,
    output logic              carry_out,
    output logic [BAND_W-1:0] band_out
);
    logic [N_W-1:0] ratio_w;
    logic           swallow_w;
    logic           tc_w;

    ser_telegram_port #(.N_W(N_W), .BAND_W(BAND_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .sdat    (ser_data),
        .sclk    (ser_clk),
        .sen     (ser_en),
        .ratio_o (ratio_w),
        .band_o  (band_out)
    );

    dm_prescaler #(.A_W(A_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .swallow_i (swallow_w),
        .tc_o      (tc_w)
    );

    swallow_main_ctl #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tc_i      (tc_w),
        .ratio_i   (ratio_w),
        .swallow_o (swallow_w),
        .carry_o   (carry_out),
        .div_o     (div_out)
    );

    // R10
    div_rise_with_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_out) |-> carry_out);

    // R10
    carry_means_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> div_out);
endmodule

// File: tb/serial_ratio_divider_tb.sv
module serial_ratio_divider_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_en = 1'b0;
    logic       div_out;
    logic       carry_out;
    logic [2:0] band_out;

    int n_checks = 0;
    int n_fails  = 0;

    serial_ratio_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_data  (ser_data),
        .ser_clk   (ser_clk),
        .ser_en    (ser_en),
        .div_out   (div_out),
        .carry_out (carry_out),
        .band_out  (band_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int nbits, input logic with_en);
        @(negedge clk);
        ser_en = with_en;
        idle(2);
        for (int i = 0; i < nbits; i++) begin
            ser_data = bits[i];
            ser_clk  = 1'b1;
            idle(2);
            ser_clk  = 1'b0;
            idle(2);
        end
        ser_en = 1'b0;
        idle(3);
    endtask

    function automatic logic [15:0] telegram(input int n, input logic [2:0] band);
        logic [12:0] nn;
        nn = 13'(n);
        return {band, ~nn};
    endfunction

    task automatic wait_carry(output int ok);
        int t = 0;
        ok = 0;
        while (t < 20000) begin
            @(negedge clk);
            if (carry_out) begin
                ok = 1;
                break;
            end
            t++;
        end
    endtask

    task automatic measure(output int n);
        int ok;
        wait_carry(ok);
        n = 0;
        if (ok == 1) begin
            wait_carry(ok);
            n = 0;
            // count from this carry to the next one
            do begin
                @(negedge clk);
                n++;
            end while (!carry_out && n < 20000);
        end
    endtask

    task automatic load_and_measure(input string req, input int n_load, input logic [2:0] band, input int exp);
        int per;
        shift_bits(32'(telegram(n_load, band)), 16, 1'b1);
        measure(per);
        check(req, per, exp);
    endtask

    task automatic t_reset();
        int per;
        check("R1 band", int'(band_out), 0);
        check("R1 carry", int'(carry_out), 0);
        measure(per);
        check("R1 period", per, 256);
    endtask

    task automatic t_basic();
        load_and_measure("R2 N=300", 300, 3'b000, 300);
        load_and_measure("R3 A=15", 271, 3'b000, 271);
        load_and_measure("R3 A=0", 256, 3'b000, 256);
        load_and_measure("R4 max", 8191, 3'b000, 8191);
        load_and_measure("R5 clamp", 100, 3'b000, 256);
    endtask

    task automatic t_band();
        shift_bits(32'(telegram(400, 3'b110)), 16, 1'b1);
        check("R6 band 110", int'(band_out), 6);
        shift_bits(32'(telegram(400, 3'b001)), 16, 1'b1);
        check("R6 band 001", int'(band_out), 1);
    endtask

    task automatic t_ignore();
        int per;
        shift_bits(32'(telegram(333, 3'b111)), 16, 1'b0);
        check("R7 band unchanged", int'(band_out), 1);
        measure(per);
        check("R7 period unchanged", per, 400);
    endtask

    task automatic t_overlong();
        logic [31:0] bits;
        bits = {12'h0, telegram(500, 3'b101), 4'b1010};
        shift_bits(bits, 20, 1'b1);
        check("R8 band last16", int'(band_out), 5);
        measure(per_r8);
        check("R8 period last16", per_r8, 500);
    endtask
    int per_r8;

    task automatic t_no_truncate();
        int ok;
        int cnt;
        int per;
        load_and_measure("R9 setup", 1000, 3'b000, 1000);
        wait_carry(ok);
        cnt = 0;
        fork
            begin
                do begin
                    @(negedge clk);
                    cnt++;
                end while (!carry_out && cnt < 20000);
            end
            begin
                idle(20);
                shift_bits(32'(telegram(400, 3'b000)), 16, 1'b1);
            end
        join
        check("R9 running period kept", cnt, 1000);
        per = 0;
        do begin
            @(negedge clk);
            per++;
        end while (!carry_out && per < 20000);
        check("R9 next period new", per, 400);
    endtask

    task automatic t_carry();
        int ok;
        wait_carry(ok);
        check("R10 div high with carry", int'(div_out), 1);
        @(negedge clk);
        check("R10 carry one cycle", int'(carry_out), 0);
        idle(2);
        check("R10 div still high", int'(div_out), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_basic();
        t_band();
        t_ignore();
        t_overlong();
        t_no_truncate();
        t_carry();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule